// File: doc/BRIEF.md
# I2C Bus Condition and Clock-Hold Monitor

This block sits beside a serial shift engine when that engine runs as an I2C node. It samples the shared open-drain data and clock lines and recognises bus START and STOP conditions. A START raises a sticky flag that can request an interrupt. A STOP raises a separate status flag. The block never drives a line high. It only asks the pad to pull a line low or to let it float.

When the shift engine's bit counter finishes, the block stretches the clock by pulling it low. It keeps doing so until software sets a release bit. A newly seen START clears that release bit, so the next transfer stretches again. While the node sends, the block compares each bit it releases with what the bus shows. When another master wins arbitration, the block stops pulling the data line until the next START. The STOP flag uses the same auto-clear rule as the counter flag: a nonzero counter reload clears it, unless the keep-flag control is set.

Top module: `i2c_cond_hold`

## Requirements
- R1: The data pull-down `sda_pull` is 1 exactly when the block is enabled (`i2c_en`=1, `sw_reset`=0), `tx_sda`=0 and `arb_lost`=0. Line levels are never driven high.
- R2: A fall of the data line while the clock line is high sets `start_flag`. The flag is visible at the third rising clock edge after the line change. A `start_clr` pulse clears it. A detection in the same cycle wins over the clear.
- R3: `irq` equals `start_flag` AND `start_ie`.
- R4: A detected START clears the release bit `rel_bit`.
- R5: `scl_pull` is 1 while the block is enabled, `cnt_done`=1 and `rel_bit`=0. A `rel_wr` strobe with `rel_wdata`=1 sets `rel_bit` and releases the clock.
- R6: A rise of the data line while the clock line is high sets `stop_flag`, with the same three-edge latency as R2.
- R7: `stop_flag` clears on a `cnt_load` strobe with a nonzero `cnt_load_val` only when `keep_flag`=0. A zero value, or `keep_flag`=1, leaves it set.
- R8: With `tx_arb`=1, if the block has released the data line while the clock is high and the line reads low, `arb_lost` sets. From then on `sda_pull` stays 0 until a START clears `arb_lost`. The release is judged against the pull level from as many cycles back as the synchronizer is deep.
- R9: While `sw_reset`=1, all flags and the release bit clear and both pulls are 0. Hardware reset leaves the same state.
- R10: Data line changes while the clock line is low produce neither a START nor a STOP.
- R11: With `i2c_en`=0 there are no pulls and no condition detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_reset | input | 1 | Software reset; holds the logic cleared |
| i2c_en | input | 1 | I2C mode enable |
| sda_in | input | 1 | Raw data line level |
| scl_in | input | 1 | Raw clock line level |
| tx_sda | input | 1 | Bit the shift engine sends (0 = pull low) |
| tx_arb | input | 1 | Arbitration window: node is sending |
| cnt_done | input | 1 | Bit counter complete flag |
| cnt_load | input | 1 | Counter load strobe |
| cnt_load_val | input | CNT_W | Value loaded into the counter |
| keep_flag | input | 1 | 1 blocks the reload auto-clear |
| rel_wr | input | 1 | Write strobe for the release bit |
| rel_wdata | input | 1 | Value written to the release bit |
| start_ie | input | 1 | START interrupt enable |
| start_clr | input | 1 | Clear strobe for the START flag |
| sda_pull | output | 1 | Pull data line low |
| scl_pull | output | 1 | Pull clock line low |
| start_flag | output | 1 | START seen |
| stop_flag | output | 1 | STOP seen |
| rel_bit | output | 1 | Clock release bit |
| arb_lost | output | 1 | Arbitration lost |
| irq | output | 1 | START interrupt request |

## Verification
The hardest case to reach is a real arbitration loss that no false loss precedes. The block's own pull-down stays visible through the synchronizer for two cycles after it lets go. The bench therefore first makes the block pull the data line low with the clock low. It then raises the clock and releases the line, and checks that no loss is reported during the synchronizer lag. Only after that does it let a second master hold the line low across a clock-high period, entering through a clock-low phase so that no START hides the loss. A START then has to clear the loss and give back the data drive.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
    typedef struct packed {
        logic start;
        logic stop;
        logic rel;
        logic lost;
    } cond_state_t;

    localparam cond_state_t COND_IDLE = '{start: 1'b0, stop: 1'b0, rel: 1'b0, lost: 1'b0};
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] sh_d, sh_q;

    generate
        if (STAGES > 1) begin : g_chain
            always_comb sh_d = {sh_q[TOP-1:0], d};
        end else begin : g_single
            always_comb sh_d = d;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q = sh_q[TOP];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sda_s,
    input  logic scl_s,
    output logic start_det,
    output logic stop_det
);
    logic sda_prev_d, sda_prev_q;
    logic scl_prev_d, scl_prev_q;

    always_comb begin
        sda_prev_d = sda_s;
        scl_prev_d = scl_s;
        start_det  = en & scl_s & scl_prev_q &  sda_prev_q & ~sda_s;
        stop_det   = en & scl_s & scl_prev_q & ~sda_prev_q &  sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_prev_q <= 1'b1;
            scl_prev_q <= 1'b1;
        end else begin
            sda_prev_q <= sda_prev_d;
            scl_prev_q <= scl_prev_d;
        end
    end
endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tx_arb,
    input  logic pull_now,
    input  logic sda_s,
    input  logic scl_s,
    output logic lost_set
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] hist_d, hist_q;

    generate
        if (STAGES > 1) begin : g_hist
            always_comb hist_d = {hist_q[TOP-1:0], pull_now};
        end else begin : g_hist1
            always_comb hist_d = pull_now;
        end
    endgenerate

    always_comb lost_set = en & tx_arb & scl_s & ~sda_s & ~hist_q[TOP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end
endmodule

// File: rtl/i2c_cond_hold.sv
module i2c_cond_hold
    import i2c_cond_pkg::*;
#(
    parameter int CNT_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_reset,
    input  logic             i2c_en,
    input  logic             sda_in,
    input  logic             scl_in,
    input  logic             tx_sda,
    input  logic             tx_arb,
    input  logic             cnt_done,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_load_val,
    input  logic             keep_flag,
    input  logic             rel_wr,
    input  logic             rel_wdata,
    input  logic             start_ie,
    input  logic             start_clr,
    output logic             sda_pull,
    output logic             scl_pull,
    output logic             start_flag,
    output logic             stop_flag,
    output logic             rel_bit,
    output logic             arb_lost,
    output logic             irq
);
    cond_state_t st_d, st_q;

    logic en;
    logic sda_s, scl_s;
    logic start_det, stop_det;
    logic lost_set;
    logic reload_nz;

    assign en = i2c_en & ~sw_reset;

    i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s)
    );

    i2c_cond_detect u_det (
        .clk(clk), .rst_n(rst_n), .en(en),
        .sda_s(sda_s), .scl_s(scl_s),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_arb_monitor #(.STAGES(SYNC_STAGES)) u_arb (
        .clk(clk), .rst_n(rst_n), .en(en), .tx_arb(tx_arb),
        .pull_now(sda_pull), .sda_s(sda_s), .scl_s(scl_s),
        .lost_set(lost_set)
    );

    always_comb begin
        reload_nz = cnt_load & (|cnt_load_val);
        st_d      = st_q;

        if (start_det)      st_d.start = 1'b1;
        else if (start_clr) st_d.start = 1'b0;

        if (stop_det)                     st_d.stop = 1'b1;
        else if (reload_nz && !keep_flag) st_d.stop = 1'b0;

        if (start_det)   st_d.rel = 1'b0;
        else if (rel_wr) st_d.rel = rel_wdata;

        if (start_det)     st_d.lost = 1'b0;
        else if (lost_set) st_d.lost = 1'b1;

        if (sw_reset) st_d = COND_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= COND_IDLE;
        else        st_q <= st_d;
    end

    assign sda_pull   = en & ~tx_sda & ~st_q.lost;
    assign scl_pull   = en & cnt_done & ~st_q.rel;
    assign start_flag = st_q.start;
    assign stop_flag  = st_q.stop;
    assign rel_bit    = st_q.rel;
    assign arb_lost   = st_q.lost;
    assign irq        = st_q.start & start_ie;
endmodule

// File: rtl/i2c_cond_hold_chk.sv
module i2c_cond_hold_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_reset,
    input logic             i2c_en,
    input logic             cnt_done,
    input logic             cnt_load,
    input logic [CNT_W-1:0] cnt_load_val,
    input logic             keep_flag,
    input logic             start_ie,
    input logic             sda_pull,
    input logic             scl_pull,
    input logic             start_flag,
    input logic             stop_flag,
    input logic             rel_bit,
    input logic             arb_lost,
    input logic             irq,
    input logic             start_det,
    input logic             stop_det
);
    AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (!start_flag && !stop_flag && !rel_bit && !arb_lost)); // R9

    AST_START_DROPS_REL: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !sw_reset) |=> (start_flag && !rel_bit)); // R4

    AST_STOP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !sw_reset) |=> stop_flag); // R6

    AST_STOP_RELOAD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_load && (|cnt_load_val) && !keep_flag && !stop_det) |=> !stop_flag); // R7

    AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_flag && !sw_reset && !(cnt_load && (|cnt_load_val) && !keep_flag)) |=> stop_flag); // R7

    AST_LOST_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> !sda_pull); // R8

    AST_CLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (i2c_en && !sw_reset && cnt_done && !rel_bit) |-> scl_pull); // R5

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (start_flag && start_ie)); // R3
endmodule

bind i2c_cond_hold i2c_cond_hold_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .i2c_en(i2c_en),
    .cnt_done(cnt_done), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
    .keep_flag(keep_flag), .start_ie(start_ie), .sda_pull(sda_pull),
    .scl_pull(scl_pull), .start_flag(start_flag), .stop_flag(stop_flag),
    .rel_bit(rel_bit), .arb_lost(arb_lost), .irq(irq),
    .start_det(start_det), .stop_det(stop_det)
);

// File: tb/i2c_cond_hold_test.sv
`timescale 1ns/1ps
module i2c_cond_hold_test;
    localparam int CNT_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_reset = 1'b0, i2c_en = 1'b1;
    logic ext_sda = 1'b1, ext_scl = 1'b1;
    logic tx_sda = 1'b1, tx_arb = 1'b0, cnt_done = 1'b0;
    logic cnt_load = 1'b0, keep_flag = 1'b0;
    logic [CNT_W-1:0] cnt_load_val = '0;
    logic rel_wr = 1'b0, rel_wdata = 1'b0, start_ie = 1'b0, start_clr = 1'b0;
    logic sda_in, scl_in;
    logic sda_pull, scl_pull, start_flag, stop_flag, rel_bit, arb_lost, irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    // wired-AND bus model
    assign sda_in = ext_sda & ~sda_pull;
    assign scl_in = ext_scl & ~scl_pull;

    i2c_cond_hold #(.CNT_W(CNT_W), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .i2c_en(i2c_en),
        .sda_in(sda_in), .scl_in(scl_in), .tx_sda(tx_sda), .tx_arb(tx_arb),
        .cnt_done(cnt_done), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
        .keep_flag(keep_flag), .rel_wr(rel_wr), .rel_wdata(rel_wdata),
        .start_ie(start_ie), .start_clr(start_clr), .sda_pull(sda_pull),
        .scl_pull(scl_pull), .start_flag(start_flag), .stop_flag(stop_flag),
        .rel_bit(rel_bit), .arb_lost(arb_lost), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic bus_idle();
        ext_scl = 1'b0; tick(1);
        ext_sda = 1'b1; tick(1);
        ext_scl = 1'b1; tick(4);
    endtask

    task automatic t_reset_state();
        chk("R9 start after reset", start_flag, 1'b0);
        chk("R9 stop after reset", stop_flag, 1'b0);
        chk("R9 rel after reset", rel_bit, 1'b0);
        chk("R9 lost after reset", arb_lost, 1'b0);
        chk("R9 scl pull after reset", scl_pull, 1'b0);
    endtask

    task automatic t_open_drain();
        ext_scl = 1'b0; tick(2);
        tx_sda = 1'b0; tick(1);
        chk("R1 pull on low bit", sda_pull, 1'b1);
        tx_sda = 1'b1; tick(1);
        chk("R1 release on high bit", sda_pull, 1'b0);
        tick(3);
    endtask

    task automatic t_scl_low_changes();
        ext_scl = 1'b0; tick(1);
        ext_sda = 1'b0; tick(4);
        ext_sda = 1'b1; tick(4);
        chk("R10 no start with scl low", start_flag, 1'b0);
        chk("R10 no stop with scl low", stop_flag, 1'b0);
        ext_scl = 1'b1; tick(4);
    endtask

    task automatic t_start_irq();
        bus_idle();
        start_ie = 1'b0;
        ext_sda = 1'b0; tick(2);
        chk("R2 start not yet after two edges", start_flag, 1'b0);
        tick(1);
        chk("R2 start at third edge", start_flag, 1'b1);
        chk("R3 irq masked", irq, 1'b0);
        start_ie = 1'b1; tick(1);
        chk("R3 irq enabled", irq, 1'b1);
        start_clr = 1'b1; tick(1); start_clr = 1'b0;
        chk("R2 start cleared", start_flag, 1'b0);
        chk("R3 irq gone", irq, 1'b0);
        start_ie = 1'b0;
    endtask

    task automatic t_hold_release();
        bus_idle();
        cnt_done = 1'b1; tick(1);
        chk("R5 clock held", scl_pull, 1'b1);
        rel_wdata = 1'b1; rel_wr = 1'b1; tick(1); rel_wr = 1'b0;
        chk("R5 release bit set", rel_bit, 1'b1);
        chk("R5 clock released", scl_pull, 1'b0);
        tick(4);
        ext_sda = 1'b0; tick(3);
        chk("R4 start clears release", rel_bit, 1'b0);
        chk("R5 hold resumes", scl_pull, 1'b1);
        cnt_done = 1'b0; tick(4);
    endtask

    task automatic t_stop_rules();
        bus_idle();
        ext_sda = 1'b0; tick(4);          // START, leaves sda low, scl high
        ext_sda = 1'b1; tick(2);
        chk("R6 stop not yet", stop_flag, 1'b0);
        tick(1);
        chk("R6 stop set", stop_flag, 1'b1);
        keep_flag = 1'b1; cnt_load_val = 5'd5; cnt_load = 1'b1; tick(1); cnt_load = 1'b0;
        chk("R7 keep blocks clear", stop_flag, 1'b1);
        keep_flag = 1'b0; cnt_load_val = 5'd0; cnt_load = 1'b1; tick(1); cnt_load = 1'b0;
        chk("R7 zero load keeps", stop_flag, 1'b1);
        cnt_load_val = 5'd5; cnt_load = 1'b1; tick(1); cnt_load = 1'b0;
        chk("R7 nonzero load clears", stop_flag, 1'b0);
    endtask

    task automatic t_arbitration();
        ext_scl = 1'b0; tick(1);
        tx_sda = 1'b0; tick(2);
        ext_scl = 1'b1; tick(4);
        tx_arb = 1'b1;
        tx_sda = 1'b1; tick(5);
        chk("R8 no false loss on own release", arb_lost, 1'b0);
        ext_scl = 1'b0; tick(1);
        ext_sda = 1'b0; tick(2);
        ext_scl = 1'b1; tick(4);
        chk("R8 loss detected", arb_lost, 1'b1);
        tx_sda = 1'b0; tick(1);
        chk("R8 no drive after loss", sda_pull, 1'b0);
        tx_arb = 1'b0; tx_sda = 1'b1;
        bus_idle();
        ext_sda = 1'b0; tick(4);
        chk("R8 start clears loss", arb_lost, 1'b0);
        tx_sda = 1'b0; tick(1);
        chk("R8 drive restored", sda_pull, 1'b1);
        tx_sda = 1'b1;
        bus_idle();
    endtask

    task automatic t_soft_reset();
        ext_sda = 1'b0; tick(4);
        ext_sda = 1'b1; tick(4);
        rel_wdata = 1'b1; rel_wr = 1'b1; tick(1); rel_wr = 1'b0;
        tx_sda = 1'b0; cnt_done = 1'b1;
        sw_reset = 1'b1; tick(1);
        chk("R9 start cleared", start_flag, 1'b0);
        chk("R9 stop cleared", stop_flag, 1'b0);
        chk("R9 rel cleared", rel_bit, 1'b0);
        chk("R9 sda released", sda_pull, 1'b0);
        chk("R9 scl released", scl_pull, 1'b0);
        sw_reset = 1'b0; tx_sda = 1'b1; cnt_done = 1'b0;
        bus_idle();
    endtask

    task automatic t_disabled();
        i2c_en = 1'b0;
        tx_sda = 1'b0; cnt_done = 1'b1; tick(1);
        chk("R11 no data pull", sda_pull, 1'b0);
        chk("R11 no clock pull", scl_pull, 1'b0);
        ext_sda = 1'b0; tick(4);
        chk("R11 no start when off", start_flag, 1'b0);
        ext_sda = 1'b1; tick(4);
        chk("R11 no stop when off", stop_flag, 1'b0);
        tx_sda = 1'b1; cnt_done = 1'b0; i2c_en = 1'b1;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(3);
        t_reset_state();
        t_open_drain();
        t_scl_low_changes();
        t_start_irq();
        t_hold_release();
        t_stop_rules();
        t_arbitration();
        t_soft_reset();
        t_disabled();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule